// File: doc/BRIEF.md
# Write Cycle Qualifier

This block is the front end of a byte-wide memory command path. It takes the raw asynchronous bus strobes (active-low chip select, write strobe and output enable), together with the raw address and data buses and a digital supply-low flag. It samples all of them on a fast local clock and decides which bus activity is a real write. For each real write it hands the command decoder one captured address, one captured data byte and a single-cycle write-valid pulse.

A write window is open only while chip select and write strobe are both low and output enable is high. Either strobe can open or close the window. The address is taken in the first sampled cycle of the window, which is the later of the two falling edges. The data is taken in the sample that sees the window close, which is the earlier of the two rising edges. A window produces no write when it is shorter than a configurable number of sample clocks, when output enable falls while it is open, or when the supply-low flag is seen during it. Outputs keep their last values between writes.

Top module: `wr_qualifier`

## Requirements
- R1: After reset, `wr_valid` is 0 and `wr_addr` and `wr_data` are all zeros.
- R2: Each qualified write produces exactly one `wr_valid` pulse, one clock wide. It is visible in the clock period that begins 2 rising edges after the first edge that samples a strobe high (that sample plus two synchroniser stages and one output register).
- R3: `wr_addr` carries the address bus value sampled together with the first sample in which chip select and write strobe are both low with output enable high. Later address changes in the window have no effect.
- R4: `wr_data` carries the data bus value sampled together with the first sample in which either chip select or write strobe is back high. Data changes before or after that sample have no effect.
- R5: While output enable is held low, a low pulse on chip select and write strobe of any length produces no write.
- R6: If output enable falls while a window is open, that window produces no write.
- R7: A window lasting fewer than MIN_PULSE samples produces no write. A window lasting MIN_PULSE samples or more produces one. This holds for both orders of falling and both orders of rising strobes.
- R8: If `supply_low` is sampled high in any cycle of a window, that window produces no write. This includes a single sample in the middle of the window.
- R9: A window that produces no write leaves `wr_addr` and `wr_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_raw | input | 1 | Raw chip select, active low |
| wr_n_raw | input | 1 | Raw write strobe, active low |
| oe_n_raw | input | 1 | Raw output enable, active low |
| addr_raw | input | AW | Raw address bus |
| data_raw | input | DW | Raw data bus |
| supply_low | input | 1 | Digital supply-low flag, active high |
| wr_valid | output | 1 | One-cycle pulse for a qualified write |
| wr_addr | output | AW | Captured write address |
| wr_data | output | DW | Captured write data |

## Verification
The bench sweeps window lengths on both sides of the width threshold, in all four combinations of which strobe falls first and which rises first. A design that compared the width against the wrong threshold would let a window one sample too short through, or would drop the shortest legal one. A design that latched on a single strobe's edges would capture the stale address seen before the second fall, or the data driven after the first rise. The bench also drops output enable mid-window, raises supply-low for one sample in the middle of a window, and holds output enable low for a whole window. A design that checked these conditions only at the window's edges would let such writes through. A design that loaded its output registers regardless of qualification would change `wr_addr` and `wr_data` even when no pulse is issued.

// File: rtl/wq_pkg.sv
package wq_pkg;
  // Saturating increment used by the window-length counter.
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // A window qualifies once its sampled length reaches the threshold.
  function automatic logic width_ok(int unsigned len, int unsigned lim);
    return len >= lim;
  endfunction
endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/wq_window.sv
module wq_window #(
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 8,
  parameter int unsigned MINP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic          low,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int unsigned CW = $clog2(MINP + 1);

  logic          act_q;
  logic [CW-1:0] len_q;
  logic          low_seen_q;
  logic [AW-1:0] addr_hold_q;

  // Named events for the assertions.
  wire act       = ~cs_n & ~wr_n & oe_n;
  wire win_start = act & ~act_q;
  wire win_end   = act_q & ~act;
  wire oe_abort  = win_end & ~cs_n & ~wr_n & ~oe_n;
  wire low_any   = low_seen_q | low;
  wire long_enough = wq_pkg::width_ok(32'(len_q), MINP);
  wire qualify   = win_end & long_enough & ~low_any & ~oe_abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      len_q       <= '0;
      low_seen_q  <= 1'b0;
      addr_hold_q <= '0;
    end else begin
      act_q <= act;
      if (win_start) begin
        len_q       <= CW'(1);
        low_seen_q  <= low;
        addr_hold_q <= addr;
      end else if (act) begin
        len_q      <= CW'(wq_pkg::sat_inc(32'(len_q), MINP));
        low_seen_q <= low_seen_q | low;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= qualify;
      if (qualify) begin
        wr_addr <= addr_hold_q;
        wr_data <= data;
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  a_r2_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(win_end));
  a_r6_oe_high_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(oe_n));
  a_r8_no_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(low_any));
  a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> ($stable(wr_addr) && $stable(wr_data)));
  a_r7_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(len_q) <= MINP);
endmodule

// File: rtl/wr_qualifier.sv
module wr_qualifier #(
  parameter int unsigned AW        = 12,
  parameter int unsigned DW        = 8,
  parameter int unsigned MIN_PULSE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_raw,
  input  logic          wr_n_raw,
  input  logic          oe_n_raw,
  input  logic [AW-1:0] addr_raw,
  input  logic [DW-1:0] data_raw,
  input  logic          supply_low,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int unsigned SW = AW + DW + 4;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 3'b111, {DW{1'b0}}, {AW{1'b0}}};

  logic [SW-1:0] raw_bus, sync_bus;
  logic          cs_s, wr_s, oe_s, low_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] data_s;

  assign raw_bus = {supply_low, oe_n_raw, wr_n_raw, cs_n_raw, data_raw, addr_raw};

  // Strobes, buses and flag share one synchroniser so they stay aligned.
  wq_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign {low_s, oe_s, wr_s, cs_s, data_s, addr_s} = sync_bus;

  wq_window #(.AW(AW), .DW(DW), .MINP(MIN_PULSE)) u_win (
    .clk(clk), .rst_n(rst_n),
    .cs_n(cs_s), .wr_n(wr_s), .oe_n(oe_s), .low(low_s),
    .addr(addr_s), .data(data_s),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wr_valid);
endmodule

// File: tb/tb_wr_qualifier.sv
module tb_wr_qualifier;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int MINP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1, low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int tests = 0;
  int fails = 0;
  logic [AW-1:0] last_a = '0;
  logic [DW-1:0] last_d = '0;

  always #4 clk = ~clk;

  wr_qualifier #(.AW(AW), .DW(DW), .MIN_PULSE(MINP)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n_raw(cs_n), .wr_n_raw(wr_n), .oe_n_raw(oe_n),
    .addr_raw(addr), .data_raw(data), .supply_low(low),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // fall_wr_first / rise_wr_first pick the strobe order; n = active samples.
  // low_mode: 0 none, 1 whole window, 2 one mid sample.
  // oe_mode: 0 high, 1 low throughout, 2 falls mid window.
  task automatic run_write(int n, bit fall_wr_first, bit rise_wr_first,
                           int low_mode, int oe_mode,
                           logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    int pulses = 0;
    int first_i = 0;
    bit expect_wr = (n >= MINP) && (low_mode == 0) && (oe_mode == 0);
    @(negedge clk);
    if (oe_mode == 1) oe_n = 1'b0;
    if (fall_wr_first) wr_n = 1'b0; else cs_n = 1'b0;
    addr = ~a; data = ~d;
    repeat (2) @(negedge clk);
    if (fall_wr_first) cs_n = 1'b0; else wr_n = 1'b0;
    addr = a;
    if (low_mode == 1) low = 1'b1;
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      addr = a ^ 12'h3C5;
      data = d ^ 8'h5A;
      if (low_mode == 2) low = (k == n / 2);
      if (oe_mode == 2 && k == n / 2) oe_n = 1'b0;
    end
    @(negedge clk);
    if (rise_wr_first) wr_n = 1'b1; else cs_n = 1'b1;
    data = d; low = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == 1) begin
        cs_n = 1'b1; wr_n = 1'b1; oe_n = 1'b1;
        data = ~d; addr = ~a;
      end
      if (wr_valid) begin
        pulses++;
        if (first_i == 0) first_i = i;
      end
    end
    chk({tag, " pulse count"}, pulses, expect_wr ? 1 : 0);
    if (expect_wr) begin
      chk("R2 pulse latency", first_i, 3);
      chk("R3 captured address", int'(wr_addr), int'(a));
      chk("R4 captured data", int'(wr_data), int'(d));
      last_a = a; last_d = d;
    end else begin
      chk("R9 address held", int'(wr_addr), int'(last_a));
      chk("R9 data held", int'(wr_data), int'(last_d));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(wr_valid), 0);
    chk("R1 reset addr", int'(wr_addr), 0);
    chk("R1 reset data", int'(wr_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7 width sweep over all strobe orderings.
    for (int n = 1; n <= 7; n++)
      for (int ord = 0; ord < 4; ord++)
        run_write(n, ord[0], ord[1], 0, 0,
                  AW'(n * 37 + ord * 5 + 1), DW'(n * 11 + ord * 3 + 7), "R7");

    run_write(6, 1'b0, 1'b0, 0, 1, 12'h123, 8'hA1, "R5");
    run_write(6, 1'b1, 1'b0, 0, 2, 12'h234, 8'hB2, "R6");
    run_write(6, 1'b0, 1'b1, 1, 0, 12'h345, 8'hC3, "R8 whole");
    run_write(6, 1'b1, 1'b1, 2, 0, 12'h456, 8'hD4, "R8 mid");
    run_write(MINP, 1'b1, 1'b0, 0, 0, 12'hFFF, 8'hFF, "R2 final");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule